// File: doc/BRIEF.md
# Power-Good Supervisor with Qualified Release

This block produces the power-good indication of a switching regulator. Digitized comparator flags come in from the analog side. Two flags carry the under-voltage window: one says the output is above the rising (set) level, and one says it is above the lower falling (clear) level. The other two flags say whether the regulator is enabled and whether a latched fault is active. Each flag is synchronized and deglitched. The two window flags then pass through a hysteresis latch, so the "output valid" state sets and clears at different voltages.

The indication is active low and meant for an open-drain pad. The block drives a pad-enable, which is high while the pad must pull low, and a status bit, which is high when power is good. Power-good is released only after the qualified condition has held for a full release delay. The delay is counted in ticks of a tick-enable strobe. A dropout pulls the indication low on the next register stage, and every recovery starts a fresh, full delay. The default delay is 500000 ticks, which is 10 ms at 50 MHz with a tick on every clock.

Top module: `pgood_supervisor`

## Requirements
- R1: During synchronous reset, and after it until the release delay has run, `pg_status` is 0 and `pg_pad_oe` is 1. With the output not valid, `pg_status` stays 0 however long the enable is held.
- R2: When all four raw flags become good in the same clock (rise=1, hold=1, en=1, fault=0) and `tick_en` is high every clock, `pg_status` is still 0 after DELAY_TICKS+5 clock edges and becomes 1 after exactly DELAY_TICKS+6 edges.
- R3: `pg_pad_oe` is always the inverse of `pg_status`. 1 means the pad is pulled low.
- R4: A raw window dropout (hold=0) that lasts two or more clocks clears `pg_status` after exactly 6 clock edges. It is still 1 after 5 edges.
- R5: After a dropout, the release needs a fresh full delay. `pg_status` returns to 1 exactly DELAY_TICKS+6 edges after the raw flags recover.
- R6: Hysteresis: the valid state sets only when the rise flag is 1. It clears only when the hold flag is 0, and clear wins if both conditions apply. With rise=0 and hold=1 the state is kept, whether it was set or clear.
- R7: A raw enable going low, or a raw fault going high, clears `pg_status` after 6 edges. Once it is removed, release again takes DELAY_TICKS+6 edges.
- R8: Each flag is decided by a 2-of-3 majority over its last three synchronized samples. A raw pulse lasting one clock has no effect on `pg_status`. A pulse lasting two clocks acts.
- R9: The release counter advances only on clocks where `tick_en` is 1. With `tick_en` held at 0, power-good is never released. After `tick_en` returns to 1 on a qualified output, `pg_status` rises DELAY_TICKS+1 edges later.
- R10: The counter saturates at DELAY_TICKS and never wraps, so `pg_status` stays 1 for as long as the output remains qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Release-delay time base strobe |
| uv_rise_raw | input | 1 | Output above the rising (set) threshold, asynchronous |
| uv_hold_raw | input | 1 | Output above the falling (clear) threshold, asynchronous |
| en_raw | input | 1 | Regulator enable, asynchronous |
| fault_raw | input | 1 | Latched fault active, asynchronous |
| pg_pad_oe | output | 1 | Open-drain pull-down enable (1 = pull pad low) |
| pg_status | output | 1 | Power good (1 = good) |

## Verification
The main release path is tried with a clean simultaneous step of all flags. This pins the exact release edge and checks that the indication holds through several delay lengths, which separates a saturating counter from a wrapping one. One-clock and two-clock dropout pulses tell the majority deglitch apart from a plain synchronizer, and the recovery from the two-clock pulse shows whether the counter really restarts. Rise-only and hold-only window patterns separate a true hysteresis latch from a single comparator. Enable, fault and stalled-tick patterns each show that a gate or the time base stops the release on its own.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int NUM_FLAGS   = 4;
    localparam int SYNC_STAGES = 2;
    localparam int VOTE_TAPS   = 3;

    localparam int IDX_RISE  = 0;
    localparam int IDX_HOLD  = 1;
    localparam int IDX_EN    = 2;
    localparam int IDX_FAULT = 3;

    typedef struct packed {
        logic fault;
        logic en;
        logic hold;
        logic rise;
    } flags_t;

    typedef struct packed {
        logic uv_valid;
        logic gate_ok;
    } qual_t;

    function automatic logic vote_major(input logic [VOTE_TAPS-1:0] v);
        return $countones(v) > (VOTE_TAPS / 2);
    endfunction

endpackage

// File: rtl/pg_flag_cond.sv
module pg_flag_cond
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic clean_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   vote_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            vote_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            vote_q <= {vote_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    assign clean_out = vote_major(vote_q);
endmodule

// File: rtl/pg_window.sv
module pg_window (
    input  logic clk,
    input  logic rst,
    input  logic above_set,
    input  logic above_clr,
    output logic valid
);
    always_ff @(posedge clk) begin
        if (rst)
            valid <= 1'b0;
        else if (!above_clr)
            valid <= 1'b0;
        else if (above_set)
            valid <= 1'b1;
    end
endmodule

// File: rtl/pg_release_timer.sv
module pg_release_timer #(
    parameter int DELAY_TICKS = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic qualify,
    input  logic tick,
    output logic [$clog2(DELAY_TICKS+1)-1:0] cnt,
    output logic pg
);
    localparam int CW = $clog2(DELAY_TICKS + 1);
    localparam logic [CW-1:0] TERM = CW'(DELAY_TICKS);

    logic done;
    assign done = (cnt == TERM);

    always_ff @(posedge clk) begin
        if (rst || !qualify) begin
            cnt <= '0;
            pg  <= 1'b0;
        end else begin
            if (tick && !done)
                cnt <= cnt + 1'b1;
            pg <= done;
        end
    end
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
    import pg_pkg::*;
#(
    parameter int DELAY_TICKS = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic uv_rise_raw,
    input  logic uv_hold_raw,
    input  logic en_raw,
    input  logic fault_raw,
    output logic pg_pad_oe,
    output logic pg_status
);
    localparam int CW = $clog2(DELAY_TICKS + 1);

    logic [NUM_FLAGS-1:0] raw_vec;
    logic [NUM_FLAGS-1:0] clean_vec;
    flags_t               clean;
    qual_t                qual_q;
    logic                 qualify;
    logic                 uv_valid;
    logic                 gate_ok;
    logic                 rise_c;
    logic                 hold_c;
    logic [CW-1:0]        release_cnt;

    assign raw_vec[IDX_RISE]  = uv_rise_raw;
    assign raw_vec[IDX_HOLD]  = uv_hold_raw;
    assign raw_vec[IDX_EN]    = en_raw;
    assign raw_vec[IDX_FAULT] = fault_raw;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cond
        pg_flag_cond u_cond (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (raw_vec[i]),
            .clean_out(clean_vec[i])
        );
    end

    assign clean = flags_t'(clean_vec);
    assign rise_c = clean.rise;
    assign hold_c = clean.hold;

    pg_window u_window (
        .clk      (clk),
        .rst      (rst),
        .above_set(rise_c),
        .above_clr(hold_c),
        .valid    (uv_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)
            gate_ok <= 1'b0;
        else
            gate_ok <= clean.en & ~clean.fault;
    end

    assign qual_q.uv_valid = uv_valid;
    assign qual_q.gate_ok  = gate_ok;
    assign qualify = &qual_q;

    pg_release_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .qualify(qualify),
        .tick   (tick_en),
        .cnt    (release_cnt),
        .pg     (pg_status)
    );

    assign pg_pad_oe = ~pg_status;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
    parameter int DELAY_TICKS = 500000
) (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic pg_status,
    input logic qualify,
    input logic gate_ok,
    input logic uv_valid,
    input logic rise_c,
    input logic hold_c,
    input logic [$clog2(DELAY_TICKS+1)-1:0] release_cnt
);
    localparam int CW = $clog2(DELAY_TICKS + 1);
    localparam logic [CW-1:0] TERM = CW'(DELAY_TICKS);

    AST_RESET_LOW: assert property (@(posedge clk) rst |=> !pg_status); // R1
    AST_RELEASE_AT_TERM: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_status) |-> $past(release_cnt) == TERM); // R2
    AST_DROP_NEXT: assert property (@(posedge clk) disable iff (rst)
        !qualify |=> !pg_status); // R4
    AST_HYST_KEEP_SET: assert property (@(posedge clk) disable iff (rst)
        uv_valid && hold_c |=> uv_valid); // R6
    AST_HYST_KEEP_CLR: assert property (@(posedge clk) disable iff (rst)
        !uv_valid && !rise_c |=> !uv_valid); // R6
    AST_GATE_FORCE: assert property (@(posedge clk) disable iff (rst)
        !gate_ok |=> !pg_status); // R7
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        qualify && !tick_en |=> $stable(release_cnt)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        release_cnt <= TERM); // R10
endmodule

bind pgood_supervisor pg_checker #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .pg_status  (pg_status),
    .qualify    (qualify),
    .gate_ok    (gate_ok),
    .uv_valid   (uv_valid),
    .rise_c     (rise_c),
    .hold_c     (hold_c),
    .release_cnt(release_cnt)
);

// File: tb/sim_pgood_supervisor.sv
module sim_pgood_supervisor;
    localparam int D = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b1;
    logic uv_rise_raw = 1'b0;
    logic uv_hold_raw = 1'b0;
    logic en_raw = 1'b0;
    logic fault_raw = 1'b0;
    logic pg_pad_oe;
    logic pg_status;

    pgood_supervisor #(.DELAY_TICKS(D)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .uv_rise_raw(uv_rise_raw), .uv_hold_raw(uv_hold_raw),
        .en_raw(en_raw), .fault_raw(fault_raw),
        .pg_pad_oe(pg_pad_oe), .pg_status(pg_status)
    );

    always #10 clk = ~clk;

    int ec = 0;
    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always @(posedge clk) ec <= ec + 1;

    typedef struct {
        int    at;
        bit    exp;
        string tag;
    } item_t;
    item_t sb[$];

    task automatic check(bit ok, string tag, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d at edge %0d", tag, what, act, exp, ec);
        end
    endtask

    task automatic expect_pg(int delta, bit v, string tag);
        item_t it;
        it.at = ec + delta;
        it.exp = v;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic set_in(bit r, bit h, bit e, bit f);
        uv_rise_raw = r;
        uv_hold_raw = h;
        en_raw = e;
        fault_raw = f;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares at the scheduled edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= ec) begin
            item_t it;
            it = sb.pop_front();
            check(it.at == ec, it.tag, "schedule", ec, it.at);
            check(pg_status == it.exp, it.tag, "pg_status", int'(pg_status), int'(it.exp));
            check(pg_pad_oe == !it.exp, "R3", "pg_pad_oe", int'(pg_pad_oe), int'(!it.exp));
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d expected=%0d", ec, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pg_status == 1'b0, "R1", "pg_status in reset", int'(pg_status), 0);
        check(pg_pad_oe == 1'b1, "R1", "pg_pad_oe in reset", int'(pg_pad_oe), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(pg_status == 1'b0, "R1", "pg_status after reset", int'(pg_status), 0);
        set_in(0, 0, 1, 0);
        repeat (12) @(negedge clk);
        check(pg_status == 1'b0, "R1", "pg_status enabled, output invalid", int'(pg_status), 0);

        // R2 / R10: clean release and saturation
        set_in(1, 1, 1, 0);
        expect_pg(D + 5, 0, "R2");
        expect_pg(D + 6, 1, "R2");
        expect_pg(4 * D, 1, "R10");
        drain();

        // R8: single-clock dropout ignored
        set_in(0, 0, 1, 0);
        expect_pg(3, 1, "R8");
        expect_pg(6, 1, "R8");
        expect_pg(12, 1, "R8");
        @(negedge clk);
        set_in(1, 1, 1, 0);
        drain();

        // R4 / R5 / R8: two-clock dropout acts, fresh delay after recovery
        set_in(0, 0, 1, 0);
        expect_pg(5, 1, "R4");
        expect_pg(6, 0, "R8");
        expect_pg(D + 7, 0, "R5");
        expect_pg(D + 8, 1, "R5");
        repeat (2) @(negedge clk);
        set_in(1, 1, 1, 0);
        drain();

        // R6: hysteresis
        set_in(0, 1, 1, 0);
        expect_pg(10, 1, "R6");
        drain();
        set_in(0, 0, 1, 0);
        expect_pg(5, 1, "R4");
        expect_pg(6, 0, "R4");
        drain();
        set_in(0, 1, 1, 0);
        expect_pg(D + 10, 0, "R6");
        drain();
        set_in(1, 1, 1, 0);
        expect_pg(D + 5, 0, "R6");
        expect_pg(D + 6, 1, "R6");
        drain();

        // R7: enable
        set_in(1, 1, 0, 0);
        expect_pg(5, 1, "R7");
        expect_pg(6, 0, "R7");
        drain();
        set_in(1, 1, 1, 0);
        expect_pg(D + 5, 0, "R7");
        expect_pg(D + 6, 1, "R7");
        drain();

        // R7: fault
        set_in(1, 1, 1, 1);
        expect_pg(5, 1, "R7");
        expect_pg(6, 0, "R7");
        drain();
        set_in(1, 1, 1, 0);
        expect_pg(D + 5, 0, "R7");
        expect_pg(D + 6, 1, "R7");
        drain();

        // R9: tick gating
        set_in(0, 0, 1, 0);
        expect_pg(6, 0, "R9");
        drain();
        set_in(1, 1, 1, 0);
        tick_en = 1'b0;
        expect_pg(3 * D, 0, "R9");
        drain();
        tick_en = 1'b1;
        expect_pg(D, 0, "R9");
        expect_pg(D + 1, 1, "R9");
        drain();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule